// File: doc/BRIEF.md
# Page Table Entry Installer

This block turns a mapping request into one or more 64-bit page table entries and stores them into table memory through a single write port. A request either describes a leaf mapping (an output address plus access flags) or a pointer to a next-level table. For a leaf, the read, write and no-execute flags are turned into permission bits. A flag combination that yields no permission at all is refused.

For a 64 KiB mapping at the lowest level, with the contiguous-page option enabled, the same entry word is written to sixteen consecutive slots. The word carries a contiguity marker in its top bit and a size marker in its page-number field. Every other accepted request writes exactly one entry. Each slot is eight bytes wide, so the write address is the table base plus the slot index times eight.

A caller presents the request for one cycle while `busy` is low. It then sees the write strobes and a one-cycle `done` pulse, or instead a one-cycle `error` pulse with no write at all.

Top module: `pte_writer`

## Requirements
- R1: After reset, and in the cycle after any reset, `wr_en`, `done`, `error` and `busy` are all low; a reset during a burst stops it with no further write.
- R2: A leaf entry always sets V (bit 0), U (bit 4) and A (bit 6). A write request adds R (bit 1), W (bit 2) and D (bit 7). A read request adds R. X (bit 3) is set unless no-execute is requested.
- R3: A leaf request with write and read both clear and no-execute set is refused: `error` pulses for one cycle and nothing is written.
- R4: A leaf entry holds the output address bits 55:12 in entry bits 53:10; bits 9:8 and 62:54 are zero, and bit 63 is zero unless R5 applies.
- R5: When the contiguous option is enabled, the level is 0, the request is a leaf and the size is 64 KiB, the entry also sets bit 63 and bit 13. That word is written unchanged on sixteen consecutive cycles, to slots index..index+15.
- R6: A request that qualifies under R5 but has an index that is not a multiple of 16, or an output address that is not 64 KiB aligned, raises `error` and writes nothing.
- R7: Any other accepted leaf request writes one entry to address `tbl_base + 8*req_index`. This covers a 4 KiB leaf, a 64 KiB leaf at a nonzero level, or a 64 KiB leaf with the option disabled.
- R8: A table-pointer entry holds only V and the next-level page number in bits 53:10. Its R, W and X bits are clear, and the access flags neither change it nor cause an error.
- R9: The first write appears in the cycle after the request is accepted. `done` pulses for one cycle in the cycle after the last write. `error` pulses in the cycle after acceptance, and `done` and `error` are never high together.
- R10: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_leaf | input | 1 | 1 = leaf mapping, 0 = next-level table pointer |
| napot_en | input | 1 | Enables the 16-slot contiguous 64 KiB leaf form |
| req_big | input | 1 | 1 = 64 KiB mapping size, 0 = 4 KiB |
| req_level | input | 3 | Table level, 0 is the lowest |
| tbl_base | input | 32 | Byte address of the table |
| req_index | input | 9 | Slot index inside the table |
| out_addr | input | 56 | Output (physical) address of page or next table |
| acc_read | input | 1 | Read access requested |
| acc_write | input | 1 | Write access requested |
| acc_noexec | input | 1 | Execution forbidden |
| busy | output | 1 | A write burst is in progress |
| wr_en | output | 1 | Table memory write strobe |
| wr_addr | output | 32 | Table memory byte address |
| wr_data | output | 64 | Entry word written |
| done | output | 1 | One-cycle pulse after the last write |
| error | output | 1 | One-cycle pulse for a refused request |

## Verification
Two situations are hardest to reach from the ports. The first is a second request arriving in the middle of a sixteen-slot burst. The second is a reset landing partway through such a burst. The bench starts a contiguous 64 KiB install, pulses a conflicting single-entry request a few cycles into the writes, and checks that the burst keeps its addresses and word and that nothing extra follows. It then starts another burst and asserts reset after two writes. The table-driven part covers each alignment refusal and the three ways a 64 KiB leaf falls back to a single write.

// File: rtl/pte_pkg.sv
package pte_pkg;

    localparam int WORD_W      = 64;
    localparam int PAGE_SHIFT  = 12;
    localparam int BIG_SHIFT   = 16;
    localparam int PPN_LSB     = 10;
    localparam int SLOT_BYTES  = 8;
    localparam int SLOT_SHIFT  = $clog2(SLOT_BYTES);
    localparam int RUN_SLOTS   = 1 << (BIG_SHIFT - PAGE_SHIFT);
    localparam int RUN_CNT_W   = $clog2(RUN_SLOTS);

    // Entry bit positions: decoded by the walker, so they are fixed
    localparam int BIT_V    = 0;
    localparam int BIT_R    = 1;
    localparam int BIT_W    = 2;
    localparam int BIT_X    = 3;
    localparam int BIT_U    = 4;
    localparam int BIT_A    = 6;
    localparam int BIT_D    = 7;
    localparam int BIT_SIZE = 13;
    localparam int BIT_RUN  = 63;

    typedef struct packed {
        logic rd;
        logic wr;
        logic noexec;
    } access_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_WRITE = 1'b1
    } seq_state_t;

    function automatic logic [7:0] perm_from_access(input access_t a);
        logic [7:0] p;
        p = '0;
        p[BIT_A] = 1'b1;
        p[BIT_U] = 1'b1;
        if (a.wr) begin
            p[BIT_W] = 1'b1;
            p[BIT_R] = 1'b1;
            p[BIT_D] = 1'b1;
        end
        if (a.rd)
            p[BIT_R] = 1'b1;
        if (!a.noexec)
            p[BIT_X] = 1'b1;
        return p;
    endfunction

endpackage

// File: rtl/pte_perm_enc.sv
module pte_perm_enc
    import pte_pkg::*;
(
    input  access_t    acc,
    output logic [7:0] perm,
    output logic       perm_ok
);

    always_comb begin
        perm    = perm_from_access(acc);
        perm_ok = |{perm[BIT_R], perm[BIT_W], perm[BIT_X]};
    end

endmodule

// File: rtl/pte_word_build.sv
module pte_word_build
    import pte_pkg::*;
#(
    parameter int OA_W = 56
) (
    input  logic                   is_leaf,
    input  logic                   run_form,
    input  logic [OA_W-1:PAGE_SHIFT] page_num,
    input  logic [7:0]             perm,
    output logic [WORD_W-1:0]      word
);

    localparam int PPN_W = OA_W - PAGE_SHIFT;

    always_comb begin
        word = '0;
        word[PPN_LSB +: PPN_W] = page_num;
        word[BIT_V] = 1'b1;
        if (is_leaf) begin
            word[7:1] = perm[7:1];
            if (run_form) begin
                word[BIT_SIZE] = 1'b1;
                word[BIT_RUN]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pte_write_seq.sv
module pte_write_seq
    import pte_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 9,
    parameter int SLOTS  = RUN_SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fail,
    input  logic              multi,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  index,
    input  logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              error
);

    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] LAST_MULTI = CNT_W'(SLOTS - 1);

    seq_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  index_q;
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            cnt     <= '0;
            last    <= '0;
            base_q  <= '0;
            index_q <= '0;
            word_q  <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        if (fail) begin
                            error <= 1'b1;
                        end else begin
                            state   <= SEQ_WRITE;
                            cnt     <= '0;
                            last    <= multi ? LAST_MULTI : '0;
                            base_q  <= base;
                            index_q <= index;
                            word_q  <= word;
                        end
                    end
                end
                SEQ_WRITE: begin
                    if (cnt == last) begin
                        state <= SEQ_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        slot    = index_q + IDX_W'(cnt);
        busy    = (state == SEQ_WRITE);
        wr_en   = (state == SEQ_WRITE);
        wr_addr = base_q + (ADDR_W'(slot) << SLOT_SHIFT);
        wr_data = word_q;
    end

    AST_BURST_WORD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> $stable(wr_data)); // R5

    AST_BURST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(SLOT_BYTES))); // R5

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_en) && !wr_en)); // R9

    AST_ERROR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        error |-> (!wr_en && !$past(wr_en))); // R3

    AST_DONE_ERROR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && error)); // R9

endmodule

// File: rtl/pte_writer.sv
module pte_writer
    import pte_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 9,
    parameter int LVL_W  = 3,
    parameter int OA_W   = 56
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_leaf,
    input  logic              napot_en,
    input  logic              req_big,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [OA_W-1:0]   out_addr,
    input  logic              acc_read,
    input  logic              acc_write,
    input  logic              acc_noexec,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              error
);

    localparam int RUN_IDX_BITS = RUN_CNT_W;

    access_t           acc;
    logic [7:0]        perm;
    logic              perm_ok;
    logic              run_form;
    logic              misaligned;
    logic              fail;
    logic              accept;
    logic [WORD_W-1:0] word;

    always_comb begin
        acc        = '{rd: acc_read, wr: acc_write, noexec: acc_noexec};
        run_form   = req_leaf && napot_en && req_big && (req_level == '0);
        misaligned = run_form &&
                     ((req_index[RUN_IDX_BITS-1:0] != '0) ||
                      (out_addr[BIG_SHIFT-1:0] != '0));
        fail       = (req_leaf && !perm_ok) || misaligned;
        accept     = req_valid && !busy;
    end

    pte_perm_enc u_perm (
        .acc     (acc),
        .perm    (perm),
        .perm_ok (perm_ok)
    );

    pte_word_build #(.OA_W(OA_W)) u_word (
        .is_leaf  (req_leaf),
        .run_form (run_form),
        .page_num (out_addr[OA_W-1:PAGE_SHIFT]),
        .perm     (perm),
        .word     (word)
    );

    pte_write_seq #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .SLOTS  (RUN_SLOTS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .fail    (fail),
        .multi   (run_form),
        .base    (tbl_base),
        .index   (req_index),
        .word    (word),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .done    (done),
        .error   (error)
    );

    AST_TABLE_NO_RWX: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_leaf) |-> (word[BIT_X:BIT_R] == '0 && word[BIT_V])); // R8

    AST_LEAF_HAS_PERM: assert property (@(posedge clk) disable iff (rst)
        (accept && req_leaf && !fail) |-> (word[BIT_X:BIT_R] != '0 && word[BIT_A] && word[BIT_U])); // R2

    AST_RUN_MARKERS: assert property (@(posedge clk) disable iff (rst)
        (accept && run_form && !fail) |-> (word[BIT_RUN] && word[BIT_SIZE])); // R5

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (!wr_en && !done && !error)); // R1

endmodule

// File: tb/pte_writer_test.sv
module pte_writer_test;

    localparam int  CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h1000_0000;

    typedef struct packed {
        logic        leaf;
        logic        nen;
        logic        big;
        logic [2:0]  lvl;
        logic [8:0]  idx;
        logic [55:0] oa;
        logic        rd;
        logic        wr;
        logic        nx;
        logic        err;
        logic [4:0]  n;
        logic [63:0] word;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R2: read-only leaf, level 0
        '{1'b1,1'b0,1'b0,3'd0,9'd5,  56'h0000_0012_3456_7000,1'b1,1'b0,1'b1,1'b0,5'd1, 64'h0000_0004_8D15_9C53,4'd2},
        // R2: write+exec leaf at last slot, level 1
        '{1'b1,1'b0,1'b0,3'd1,9'd511,56'h0000_0000_8000_0000,1'b0,1'b1,1'b0,1'b0,5'd1, 64'h0000_0000_2000_00DF,4'd2},
        // R3: no permission at all
        '{1'b1,1'b0,1'b0,3'd0,9'd3,  56'h0000_0000_0000_4000,1'b0,1'b0,1'b1,1'b1,5'd0, 64'h0,4'd3},
        // R8: table pointer with no-exec-only flags
        '{1'b0,1'b1,1'b1,3'd2,9'd9,  56'h0000_0000_0004_5000,1'b0,1'b0,1'b1,1'b0,5'd1, 64'h0000_0000_0001_1401,4'd8},
        // R5: contiguous 64 KiB run
        '{1'b1,1'b1,1'b1,3'd0,9'd32, 56'h0000_0000_0123_0000,1'b1,1'b0,1'b0,1'b0,5'd16,64'h8000_0000_0048_E05B,4'd5},
        // R6: index not a multiple of 16
        '{1'b1,1'b1,1'b1,3'd0,9'd33, 56'h0000_0000_0123_0000,1'b1,1'b0,1'b0,1'b1,5'd0, 64'h0,4'd6},
        // R6: address not 64 KiB aligned
        '{1'b1,1'b1,1'b1,3'd0,9'd0,  56'h0000_0000_0123_1000,1'b1,1'b0,1'b0,1'b1,5'd0, 64'h0,4'd6},
        // R7: 64 KiB but option disabled
        '{1'b1,1'b0,1'b1,3'd0,9'd16, 56'h0000_0000_0123_0000,1'b1,1'b1,1'b1,1'b0,5'd1, 64'h0000_0000_0048_C0D7,4'd7},
        // R7: 64 KiB at level 1
        '{1'b1,1'b1,1'b1,3'd1,9'd17, 56'h0000_0000_0123_0000,1'b1,1'b0,1'b1,1'b0,5'd1, 64'h0000_0000_0048_C053,4'd7},
        // R4: widest output address
        '{1'b1,1'b0,1'b0,3'd0,9'd100,56'hFF_FFFF_FFFF_F000,   1'b1,1'b0,1'b0,1'b0,5'd1, 64'h003F_FFFF_FFFF_FC5B,4'd4},
        // R7: 4 KiB leaf with option enabled
        '{1'b1,1'b1,1'b0,3'd0,9'd7,  56'h0000_0000_0000_7000,1'b1,1'b0,1'b1,1'b0,5'd1, 64'h0000_0000_0000_1C53,4'd7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_leaf = 1'b0;
    logic        napot_en = 1'b0;
    logic        req_big = 1'b0;
    logic [2:0]  req_level = '0;
    logic [31:0] tbl_base = BASE;
    logic [8:0]  req_index = '0;
    logic [55:0] out_addr = '0;
    logic        acc_read = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_noexec = 1'b0;
    logic        busy, wr_en, done, error;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pte_writer uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_leaf(req_leaf),
        .napot_en(napot_en), .req_big(req_big), .req_level(req_level),
        .tbl_base(tbl_base), .req_index(req_index), .out_addr(out_addr),
        .acc_read(acc_read), .acc_write(acc_write), .acc_noexec(acc_noexec),
        .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .error(error)
    );

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic load(input vec_t t);
        req_leaf   = t.leaf;
        napot_en   = t.nen;
        req_big    = t.big;
        req_level  = t.lvl;
        req_index  = t.idx;
        out_addr   = t.oa;
        acc_read   = t.rd;
        acc_write  = t.wr;
        acc_noexec = t.nx;
    endtask

    function automatic logic [31:0] slot_addr(input int s);
        return BASE + 32'(s * 8);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset
        chk("R1", "wr_en after reset", 64'(wr_en), 64'd0);
        chk("R1", "done after reset",  64'(done),  64'd0);
        chk("R1", "error after reset", 64'(error), 64'd0);
        chk("R1", "busy after reset",  64'(busy),  64'd0);

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            string rq;
            t  = VECS[v];
            rq = $sformatf("R%0d", t.rq);
            load(t);
            @(negedge clk);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            for (int c = 0; c < int'(t.n) + 2; c++) begin
                bit exp_wr;
                if (c > 0) @(negedge clk);
                exp_wr = !t.err && (c < int'(t.n));
                chk(rq, $sformatf("v%0d c%0d wr_en", v, c), 64'(wr_en), 64'(exp_wr));
                if (exp_wr) begin
                    chk(rq, $sformatf("v%0d c%0d addr", v, c), 64'(wr_addr),
                        64'(slot_addr(int'(t.idx) + c)));
                    chk(rq, $sformatf("v%0d c%0d data", v, c), wr_data, t.word);
                end
                chk("R9", $sformatf("v%0d c%0d done", v, c), 64'(done),
                    64'(!t.err && c == int'(t.n)));
                chk(t.err ? rq : "R9", $sformatf("v%0d c%0d error", v, c), 64'(error),
                    64'(t.err && c == 0));
            end
        end

        // R10: second request during a contiguous burst is ignored
        load(VECS[4]);
        req_index = 9'd0;
        out_addr  = 56'h0000_0000_0001_0000;
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 20; c++) begin
            if (c > 0) @(negedge clk);
            if (c == 3) begin
                req_valid = 1'b1;
                req_index = 9'd1;
                req_big   = 1'b0;
            end else begin
                req_valid = 1'b0;
            end
            chk("R10", $sformatf("burst c%0d wr_en", c), 64'(wr_en), 64'(c < 16));
            if (c < 16) begin
                chk("R10", $sformatf("burst c%0d addr", c), 64'(wr_addr), 64'(slot_addr(c)));
                chk("R10", $sformatf("burst c%0d data", c), wr_data, 64'h8000_0000_0000_605B);
            end
            chk("R10", $sformatf("burst c%0d done", c), 64'(done), 64'(c == 16));
        end

        // R1: reset in the middle of a burst
        load(VECS[4]);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1", "mid-burst write active", 64'(wr_en), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 4; c++) begin
            chk("R1", $sformatf("post-reset c%0d wr_en", c), 64'(wr_en), 64'd0);
            chk("R1", $sformatf("post-reset c%0d busy", c), 64'(busy), 64'd0);
            chk("R1", $sformatf("post-reset c%0d done", c), 64'(done), 64'd0);
            @(negedge clk);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule